// File: doc/BRIEF.md
# Multichannel Scan and Conversion Sequencer

This block runs the acquisition sequence in front of an analog-to-digital converter. The host programs a command word, a gain word and a window of channels bounded by a first and a last channel. A conversion is launched by one of three events chosen by the command word: a write to the go register, a read of converter data, or an external active-low trigger. Once a launch is accepted, the block presents the current channel address with a valid flag, waits until the external settling-delay input is released, and then pulses a one-cycle start strobe to the converter.

When the converter reports completion, the block raises the conversion-complete flag. It also raises the end-of-scan flag if the current channel matched the last channel. With auto-increment on, it advances the channel, or wraps it to the first channel after the last one. A read of converter data can restart the scan when the end-of-scan flag is set and the restart-on-read option is enabled. A status word returns the command settings, both flags and the live current-equals-last comparison.

Top module: `scan_seq_top`

## Requirements
- R1: After synchronous reset, the command and gain words, both flags, `conv_start`, `addr_valid`, `chan_addr`, `gain_code` and `gp_out` are all zero. `status` reads 16'h0200, because the current and last channels are both 0 and therefore equal.
- R2: A write with `wr_sel`=1 stores `wr_data[7:0]` as the gain word. `gain_code` shows bits 2:0 and `gp_out` shows bits 7:6, both one clock after the write.
- R3: A write with `wr_sel`=0 stores the command word from `wr_data[7:0]`. Bit 2 is converter enable; with it at 0 nothing starts. Bits 1:0 select the start source: 00 go write only, 01 go write or data read, 10 external trigger only, 11 external trigger or data read. A go write is a write with `wr_sel`=4, any data.
- R4: An accepted launch raises `addr_valid` on the next clock, which stays high until conversion completion. `conv_start` pulses for exactly one cycle, on the clock after the first one on which `settle_busy` is sampled low while waiting. With `settle_busy` low, the pulse comes two clocks after the launch event.
- R5: `ext_trig_n` passes through a two-stage synchronizer. It triggers once, and only after it has been low for `TRIG_MIN_LOW` consecutive clocks. A shorter low pulse is ignored, and a long low level gives a single launch.
- R6: `conv_done` during a conversion sets `eoc_flag` on the next clock. `eos_flag` is set as well if the current channel equals the last channel at that moment.
- R7: Both flags are cleared by a write with `wr_sel`=5, by a `data_rd` pulse, and by an accepted launch.
- R8: A write with `wr_sel`=2 loads the first channel and the current channel, and a write with `wr_sel`=3 loads the last channel. With command bit 3 set, each completion advances the current channel by one, or reloads the first channel when the current channel equals the last. With bit 3 clear, the channel holds.
- R9: With command bit 4 set and `eos_flag` high, a `data_rd` launches a conversion even when bit 0 of the start source is 0.
- R10: `status` is {5'b0, eoc_flag, current==last, eos_flag, command[7:0]}. Command bits 5, 6 and 7 (fast throughput, calibration, interrupt enable) are stored and reported only.
- R11: Launch events that arrive while a conversion is settling or running are dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 cmd, 1 gain, 2 first, 3 last, 4 go, 5 clear) |
| wr_data | input | 16 | Write data |
| data_rd | input | 1 | Host read of converter data (one-cycle pulse) |
| ext_trig_n | input | 1 | External trigger, active low |
| settle_busy | input | 1 | Settling delay in progress |
| conv_done | input | 1 | Converter completion pulse |
| chan_addr | output | 8 | Current channel address |
| addr_valid | output | 1 | Channel address in use by a conversion |
| gain_code | output | 3 | Amplifier gain code, gain = 2^code |
| gp_out | output | 2 | General-purpose outputs |
| conv_start | output | 1 | One-cycle converter start strobe |
| eoc_flag | output | 1 | Conversion complete |
| eos_flag | output | 1 | End of scan |
| status | output | 16 | Status word |

## Verification
A go write or data read applied before clock edge 1 yields `conv_start` after edge 2 when settling is already released. If `settle_busy` is released after edge K, the strobe comes after edge K+1. An external low level seen first at edge 1 fires after edge `TRIG_MIN_LOW`+3. Flags, gain outputs and channel changes appear one edge after their cause. The bench drives on falling edges and counts falling edges from the stimulus, so each check compares the measured latency, or the value at that exact falling edge, against these figures.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    localparam int DATA_W = 16;
    localparam int CH_W   = 8;

    typedef enum logic [2:0] {
        SEL_CMD   = 3'd0,
        SEL_GAIN  = 3'd1,
        SEL_FIRST = 3'd2,
        SEL_LAST  = 3'd3,
        SEL_GO    = 3'd4,
        SEL_CLR   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic       calib;
        logic       fast;
        logic       rd_at_eos;
        logic       auto_inc;
        logic       conv_en;
        logic [1:0] src;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CONV
    } seq_state_e;

    function automatic logic src_allows_write(input logic [1:0] s);
        return !s[1];
    endfunction

    function automatic logic src_allows_read(input logic [1:0] s);
        return s[0];
    endfunction

    function automatic logic src_allows_ext(input logic [1:0] s);
        return s[1];
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input cmd_t c, input logic eos,
                                                       input logic eq, input logic eoc);
        return {5'b0, eoc, eq, eos, c};
    endfunction
endpackage

// File: rtl/trig_qualify.sv
module trig_qualify #(
    parameter int MIN_LOW = 20,
    localparam int CNT_W = $clog2(MIN_LOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_n,
    output logic fire
);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(MIN_LOW - 1);

    logic             sync_a, sync_b;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= 1'b1;
            sync_b  <= 1'b1;
            low_cnt <= '0;
        end else begin
            sync_a <= ext_n;
            sync_b <= sync_a;
            if (sync_b)
                low_cnt <= '0;
            else if (low_cnt != LIMIT)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign fire = !sync_b && (low_cnt == FIRE_AT);
endmodule

// File: rtl/chan_track.sv
module chan_track #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_first,
    input  logic            load_last,
    input  logic [CH_W-1:0] din,
    input  logic            advance,
    output logic [CH_W-1:0] cur,
    output logic            at_last
);
    logic [CH_W-1:0] first_ch, last_ch;

    assign at_last = (cur == last_ch);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_ch <= '0;
            last_ch  <= '0;
            cur      <= '0;
        end else begin
            if (load_last)
                last_ch <= din;
            if (load_first) begin
                first_ch <= din;
                cur      <= din;
            end else if (advance) begin
                cur <= at_last ? first_ch : cur + 1'b1;
            end
        end
    end
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
    import scan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic settle_busy,
    input  logic conv_done,
    input  logic clr_req,
    input  logic at_last,
    output logic conv_start,
    output logic busy,
    output logic eoc,
    output logic eos,
    output logic done_evt
);
    seq_state_e state;
    logic       accept;

    assign accept   = (state == ST_IDLE) && start_req;
    assign done_evt = (state == ST_CONV) && conv_done;
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            conv_start <= 1'b0;
            eoc        <= 1'b0;
            eos        <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (state)
                ST_IDLE:   if (accept) state <= ST_SETTLE;
                ST_SETTLE: if (!settle_busy) begin
                    conv_start <= 1'b1;
                    state      <= ST_CONV;
                end
                ST_CONV:   if (conv_done) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (done_evt) begin
                eoc <= 1'b1;
                eos <= at_last;
            end else if (clr_req || accept) begin
                eoc <= 1'b0;
                eos <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int TRIG_MIN_LOW = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic        data_rd,
    input  logic        ext_trig_n,
    input  logic        settle_busy,
    input  logic        conv_done,
    output logic [7:0]  chan_addr,
    output logic        addr_valid,
    output logic [2:0]  gain_code,
    output logic [1:0]  gp_out,
    output logic        conv_start,
    output logic        eoc_flag,
    output logic        eos_flag,
    output logic [15:0] status
);
    cmd_t            cmd;
    logic [7:0]      gain_word;
    reg_sel_e        sel;
    logic            ext_fire, at_last, done_evt;
    logic            go_wr, clr_wr, rd_launch, start_req;

    assign sel    = reg_sel_e'(wr_sel);
    assign go_wr  = wr_en && (sel == SEL_GO);
    assign clr_wr = wr_en && (sel == SEL_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            gain_word <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CMD)  cmd       <= cmd_t'(wr_data[7:0]);
            if (sel == SEL_GAIN) gain_word <= wr_data[7:0];
        end
    end

    assign gain_code = gain_word[2:0];
    assign gp_out    = gain_word[7:6];

    assign rd_launch = data_rd && (src_allows_read(cmd.src) || (cmd.rd_at_eos && eos_flag));
    assign start_req = cmd.conv_en &&
                       ((go_wr && src_allows_write(cmd.src)) ||
                        (ext_fire && src_allows_ext(cmd.src)) ||
                        rd_launch);

    trig_qualify #(.MIN_LOW(TRIG_MIN_LOW)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .ext_n (ext_trig_n),
        .fire  (ext_fire)
    );

    chan_track #(.CH_W(CH_W)) u_chan (
        .clk        (clk),
        .rst        (rst),
        .load_first (wr_en && (sel == SEL_FIRST)),
        .load_last  (wr_en && (sel == SEL_LAST)),
        .din        (wr_data[CH_W-1:0]),
        .advance    (done_evt && cmd.auto_inc),
        .cur        (chan_addr),
        .at_last    (at_last)
    );

    conv_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .settle_busy (settle_busy),
        .conv_done   (conv_done),
        .clr_req     (clr_wr || data_rd),
        .at_last     (at_last),
        .conv_start  (conv_start),
        .busy        (addr_valid),
        .eoc         (eoc_flag),
        .eos         (eos_flag),
        .done_evt    (done_evt)
    );

    assign status = pack_status(cmd, eos_flag, at_last, eoc_flag);
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [15:0] wr_data,
    input logic        settle_busy,
    input logic        conv_done,
    input logic        conv_start,
    input logic        eoc_flag,
    input logic        eos_flag,
    input logic [2:0]  gain_code
);
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_strobe_after_settle_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(!settle_busy));

    assert_eos_with_eoc_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(eos_flag) |-> eoc_flag);

    assert_clear_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd5 && !conv_done) |=> (!eoc_flag && !eos_flag));

    assert_gain_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd1) |=> (gain_code == $past(wr_data[2:0])));
endmodule

bind scan_seq_top scan_seq_chk u_chk (.*);

// File: tb/tb_scan_seq_top.sv
`timescale 1ns/1ps
module tb_scan_seq_top;
    localparam int MINLOW = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        data_rd, ext_trig_n, settle_busy, conv_done;
    logic [7:0]  chan_addr;
    logic        addr_valid, conv_start, eoc_flag, eos_flag;
    logic [2:0]  gain_code;
    logic [1:0]  gp_out;
    logic [15:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    scan_seq_top #(.TRIG_MIN_LOW(MINLOW)) dut (.*);

    // {cmd[7:0], action[3:0] (0 go write, 1 data read), expect start[3:0]}
    localparam logic [15:0] VEC [10] = '{
        16'h0401, 16'h0410, 16'h0501, 16'h0511, 16'h0600,
        16'h0610, 16'h0711, 16'h0700, 16'h0000, 16'h0110
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic done_pulse();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // called at the falling edge after the launch edge (count 1)
    task automatic wait_start(input int maxn, output int lat);
        lat = -1;
        for (int i = 1; i <= maxn; i++) begin
            if (i > 1) @(negedge clk);
            if (conv_start && lat < 0) lat = i;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hang expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int lat;
        int starts;
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; data_rd = 0;
        ext_trig_n = 1; settle_busy = 0; conv_done = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 16'h0200);
        chk("R1 chan_addr", chan_addr, 0);
        chk("R1 addr_valid", addr_valid, 0);
        chk("R1 gain/gp", {gp_out, gain_code}, 0);
        chk("R1 flags/strobe", {eoc_flag, eos_flag, conv_start}, 0);

        // R10 status layout
        wr(3'd0, 16'h00F5);
        chk("R10 status", status, 16'h02F5);
        wr(3'd0, 16'h0000);

        // R2 gain register
        wr(3'd1, 16'h00C5);
        chk("R2 gain_code", gain_code, 5);
        chk("R2 gp_out", gp_out, 3);

        // R3 start source table
        foreach (VEC[k]) begin
            wr(3'd0, {8'h00, VEC[k][15:8]});
            if (VEC[k][7:4] == 4'd0) wr(3'd4, 16'h0); else rd();
            wait_start(8, lat);
            chk($sformatf("R3 vec%0d start", k), lat, VEC[k][0] ? 2 : -1);
            if (lat > 0) done_pulse();
            wr(3'd5, 16'h0);
        end

        // R4 settling hold-off and strobe timing
        wr(3'd0, 16'h0004);
        settle_busy = 1'b1;
        wr(3'd4, 16'h0);
        chk("R4 addr_valid while settling", addr_valid, 1);
        lat = -1;
        for (int i = 1; i <= 10; i++) begin
            if (i > 1) @(negedge clk);
            if (i == 4) settle_busy = 1'b0;
            if (conv_start && lat < 0) begin
                lat = i;
                @(negedge clk);
                chk("R4 strobe single cycle", conv_start, 0);
                i++;
            end
        end
        chk("R4 start latency", lat, 5);
        done_pulse();
        chk("R4 addr_valid after done", addr_valid, 0);

        // R11 launches dropped while busy
        wr(3'd4, 16'h0);
        wait_start(4, lat);
        wr(3'd4, 16'h0);
        wait_start(8, lat);
        chk("R11 no start while busy", lat, -1);
        done_pulse();
        wait_start(8, lat);
        chk("R11 nothing queued", lat, -1);
        wr(3'd5, 16'h0);

        // R8 / R6 auto-increment scan 2..4
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd4);
        wr(3'd0, 16'h000C);
        for (int c = 2; c <= 4; c++) begin
            wr(3'd4, 16'h0);
            wait_start(4, lat);
            chk($sformatf("R8 channel at start %0d", c), chan_addr, c);
            done_pulse();
            if (c == 2) begin
                chk("R6 eoc after first", eoc_flag, 1);
                chk("R6 eos after first", eos_flag, 0);
                chk("R10 eq bit clear", status[9], 0);
            end
        end
        chk("R6 eoc at end", eoc_flag, 1);
        chk("R6 eos at end", eos_flag, 1);
        chk("R8 wrap to first", chan_addr, 2);

        // R7 flag clearing
        wr(3'd5, 16'h0);
        chk("R7 clear write", {eoc_flag, eos_flag}, 0);
        wr(3'd4, 16'h0);
        wait_start(4, lat);
        done_pulse();
        rd();
        chk("R7 read clears", eoc_flag, 0);
        wr(3'd4, 16'h0);
        wait_start(4, lat);
        done_pulse();
        chk("R7 eoc set again", eoc_flag, 1);
        wr(3'd4, 16'h0);
        chk("R7 start clears", eoc_flag, 0);
        wait_start(4, lat);
        done_pulse();
        chk("R8 channel held with increment", chan_addr, 2);

        // R8 increment off: channel holds
        wr(3'd0, 16'h0004);
        wr(3'd4, 16'h0);
        wait_start(4, lat);
        done_pulse();
        chk("R8 no increment", chan_addr, 2);

        // R9 convert-on-read at end of scan
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd5);
        wr(3'd0, 16'h001C);
        wr(3'd4, 16'h0);
        wait_start(4, lat);
        done_pulse();
        chk("R9 eos set", eos_flag, 1);
        rd();
        wait_start(6, lat);
        chk("R9 read restarts at eos", lat, 2);
        chk("R9 channel", chan_addr, 5);
        done_pulse();
        wr(3'd5, 16'h0);
        rd();
        wait_start(8, lat);
        chk("R9 no restart without eos", lat, -1);

        // R5 external trigger
        wr(3'd0, 16'h0006);
        ext_trig_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_trig_n = 1'b1;
        starts = 0;
        repeat (40) begin
            @(negedge clk);
            if (conv_start) starts++;
        end
        chk("R5 short pulse ignored", starts, 0);
        ext_trig_n = 1'b0;
        lat = -1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (conv_start && lat < 0) lat = i;
        end
        chk("R5 trigger latency", lat, MINLOW + 3);
        done_pulse();
        starts = 0;
        repeat (30) begin
            @(negedge clk);
            if (conv_start) starts++;
        end
        chk("R5 single launch per edge", starts, 0);
        ext_trig_n = 1'b1;

        done = 1;
        summary();
        $finish;
    end
endmodule